// File: doc/BRIEF.md
# Paged Packet Buffer Allocator

This block keeps the books for a packet buffer that is cut into 256-byte pages. It does not hold packet data. It tracks how many pages are free, which packet numbers are in use and how many pages each one holds. It also keeps two ordered queues of packet numbers: one for frames that have arrived and one for frames waiting to be sent. A host drives it with 16-bit command words. The operation code is in bits 7:5. For an allocation, bits 2:0 carry the page count minus one. The host also supplies a packet-number register value and a 5-bit count of pages held back for transmit.

The network side has two hooks. A receive allocation claims pages for an incoming frame and puts the new packet number on the receive queue in the same step. A transmit pop takes the head off the transmit queue once the frame has gone out. The host reads four things: a status byte for its last allocation, a queue status word, a page-count word and a busy flag. Busy is held while pages are handed back, one cycle per page.

Top module: `pma_page_alloc`

## Requirements
- R1: After reset, all pages are free, both queues are empty (queue status 16'h8080), the allocation result is 8'h80 and busy is low.
- R2: The page-count word carries the free page count in bits 15:8 and the total page count (parameter NUM_PAGES) in bits 7:0. The free count never exceeds the total.
- R3: A host allocate command (op 3'b001) asks for cmd[2:0]+1 pages. On success it gives the lowest unused packet number, so the result byte is {1'b0, number}, and the free count drops by the request. If all packet numbers are in use, the allocation fails.
- R4: A host allocation fails when the free pages minus the transmit reservation are fewer than the request. It then sets the result byte to 8'h80 and leaves the page count and the packet table unchanged.
- R5: A receive allocation ignores the transmit reservation. If enough pages and a packet number are available, rx_grant_o is high in the same cycle, rx_pkt_o gives the lowest unused number, and that number is put on the receive queue.
- R6: If a receive allocation and a host allocation come in the same cycle, the receive side is served first and takes the lowest number. The host request is then judged against the pages and numbers that remain.
- R7: The queue status word is {rx_empty, rx_head[6:0], tx_empty, tx_head[6:0]}. Each head reads 0 while its queue is empty. Both queues hand out numbers in the order they were pushed.
- R8: The enqueue command (op 3'b110) pushes the packet-number input onto the transmit queue. A tx_pop_i pulse removes the transmit head.
- R9: The remove command (op 3'b011) takes the receive head off the queue. The packet stays allocated and its pages stay in use.
- R10: The release command (op 3'b100) takes the receive head off the queue and frees it. The free command (op 3'b101) frees the packet named by the packet-number input. In both cases busy stays high for one cycle per page held, and the free count rises by one in each of those cycles.
- R11: Host commands that arrive while busy is high are ignored.
- R12: The reset command (op 3'b010) frees every page and packet number and empties both queues.
- R13: The clear-transmit command (op 3'b111) empties only the transmit queue. Page counts and the receive queue are not changed.
- R14: The no-op command (op 3'b000), and a free command naming a packet number that is not in use, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid_i | input | 1 | Host command strobe |
| cmd_word_i | input | 16 | Command word: op in 7:5, page count minus one in 2:0 |
| pnr_i | input | 7 | Packet-number register value |
| tx_reserve_i | input | 5 | Pages held back for transmit |
| busy_o | output | 1 | Pages are being handed back |
| alloc_result_o | output | 8 | Last host allocation: bit 7 failed, else packet number |
| queue_status_o | output | 16 | Queue heads and empty flags |
| mem_info_o | output | 16 | Free pages (15:8), total pages (7:0) |
| rx_alloc_i | input | 1 | Receive-side allocation request |
| rx_pages_i | input | 3 | Receive request page count minus one |
| rx_grant_o | output | 1 | Receive allocation granted this cycle |
| rx_pkt_o | output | 7 | Packet number granted to the receive side |
| tx_pop_i | input | 1 | Remove the transmit queue head |

## Verification
A host allocate and a receive allocation can land in the same cycle. Both then compete for the same free pages and the same lowest packet number. The bench drives both requests in one clock. It reads the receive grant and its number before the edge, then the host result byte and the page count after the edge. It runs three splits: both succeed, only the receive side succeeds because the host request no longer fits above the reservation, and only the host succeeds. Each expected value is computed by taking the receive demand off first.

// File: rtl/pma_pkg.sv
package pma_pkg;

    localparam int PKT_W = 7;
    localparam int OP_LSB = 5;

    typedef enum logic [2:0] {
        OP_NOP      = 3'b000,
        OP_ALLOC    = 3'b001,
        OP_RESET    = 3'b010,
        OP_RX_DROP  = 3'b011,
        OP_RX_FREE  = 3'b100,
        OP_FREE_PNR = 3'b101,
        OP_TX_PUSH  = 3'b110,
        OP_TX_CLEAR = 3'b111
    } pma_op_e;

    localparam logic [7:0] RESULT_FAIL = 8'h80;

endpackage

// File: rtl/pma_pkt_queue.sv
module pma_pkt_queue #(
    parameter int DEPTH = 8,
    parameter int W     = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush_i,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    output logic [W-1:0] head_o,
    output logic         empty_o,
    output logic         full_o
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [AW-1:0]           rd;
        logic [AW-1:0]           wr;
        logic [CW-1:0]           cnt;
    } q_t;

    q_t st_d, st_q;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        return p + 1'b1;
    endfunction

    logic do_pop, do_push;

    assign empty_o = (st_q.cnt == '0);
    assign full_o  = (st_q.cnt == CW'(DEPTH));

    always_comb begin
        head_o = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!empty_o && st_q.rd == AW'(i)) head_o = st_q.mem[i];
        end
    end

    always_comb begin
        st_d    = st_q;
        do_pop  = pop_i && !empty_o;
        do_push = push_i && (!full_o || do_pop);
        if (flush_i) begin
            st_d.rd  = '0;
            st_d.wr  = '0;
            st_d.cnt = '0;
        end else begin
            if (do_push) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (st_q.wr == AW'(i)) st_d.mem[i] = data_i;
                end
                st_d.wr = wrap_inc(st_q.wr);
            end
            if (do_pop) st_d.rd = wrap_inc(st_q.rd);
            if (do_push && !do_pop) st_d.cnt = st_q.cnt + 1'b1;
            else if (do_pop && !do_push) st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pma_pkt_table.sv
module pma_pkt_table #(
    parameter int NUM_PKTS = 8,
    parameter int CNT_W    = 4,
    parameter int IDX_W    = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_all_i,
    input  logic             set_a_i,
    input  logic [IDX_W-1:0] set_a_idx_i,
    input  logic [CNT_W-1:0] set_a_cnt_i,
    input  logic             set_b_i,
    input  logic [IDX_W-1:0] set_b_idx_i,
    input  logic [CNT_W-1:0] set_b_cnt_i,
    input  logic             drop_i,
    input  logic [IDX_W-1:0] drop_idx_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rd_used_o,
    output logic [CNT_W-1:0] rd_cnt_o,
    output logic             first_ok_o,
    output logic [IDX_W-1:0] first_idx_o,
    output logic             second_ok_o,
    output logic [IDX_W-1:0] second_idx_o
);

    typedef struct packed {
        logic [NUM_PKTS-1:0]            used;
        logic [NUM_PKTS-1:0][CNT_W-1:0] cnt;
    } tbl_t;

    tbl_t st_d, st_q;

    always_comb begin
        rd_used_o = 1'b0;
        rd_cnt_o  = '0;
        for (int i = 0; i < NUM_PKTS; i++) begin
            if (rd_idx_i == IDX_W'(i)) begin
                rd_used_o = st_q.used[i];
                rd_cnt_o  = st_q.cnt[i];
            end
        end
    end

    always_comb begin
        first_ok_o   = 1'b0;
        first_idx_o  = '0;
        second_ok_o  = 1'b0;
        second_idx_o = '0;
        for (int i = 0; i < NUM_PKTS; i++) begin
            if (!st_q.used[i]) begin
                if (!first_ok_o) begin
                    first_ok_o  = 1'b1;
                    first_idx_o = IDX_W'(i);
                end else if (!second_ok_o) begin
                    second_ok_o  = 1'b1;
                    second_idx_o = IDX_W'(i);
                end
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (clear_all_i) begin
            st_d.used = '0;
        end else begin
            for (int i = 0; i < NUM_PKTS; i++) begin
                if (drop_i && drop_idx_i == IDX_W'(i)) st_d.used[i] = 1'b0;
                if (set_a_i && set_a_idx_i == IDX_W'(i)) begin
                    st_d.used[i] = 1'b1;
                    st_d.cnt[i]  = set_a_cnt_i;
                end
                if (set_b_i && set_b_idx_i == IDX_W'(i)) begin
                    st_d.used[i] = 1'b1;
                    st_d.cnt[i]  = set_b_cnt_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/pma_page_alloc.sv
module pma_page_alloc #(
    parameter int NUM_PAGES = 16,
    parameter int NUM_PKTS  = 8,
    parameter int SIZE_W    = 3,
    parameter int RSV_W     = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid_i,
    input  logic [15:0]       cmd_word_i,
    input  logic [6:0]        pnr_i,
    input  logic [RSV_W-1:0]  tx_reserve_i,
    output logic              busy_o,
    output logic [7:0]        alloc_result_o,
    output logic [15:0]       queue_status_o,
    output logic [15:0]       mem_info_o,
    input  logic              rx_alloc_i,
    input  logic [SIZE_W-1:0] rx_pages_i,
    output logic              rx_grant_o,
    output logic [6:0]        rx_pkt_o,
    input  logic              tx_pop_i
);

    import pma_pkg::*;

    localparam int CNT_W = SIZE_W + 1;

    typedef struct packed {
        logic [7:0]       free;
        logic [CNT_W-1:0] left;
        logic [7:0]       result;
    } ctl_t;

    ctl_t st_d, st_q;

    pma_op_e          op;
    logic             acc;
    logic             c_alloc, c_reset, c_rx_drop, c_rx_free, c_free_pnr, c_tx_push, c_tx_clear;
    logic [CNT_W-1:0] need_rx, need_host;
    logic             rx_ok, host_ok, host_pkt_ok, tick;
    logic [PKT_W-1:0] host_idx;
    logic [7:0]       left_pages, rx_take, host_take;
    logic [8:0]       host_need_sum;

    logic             rxq_empty, rxq_full, txq_empty, txq_full;
    logic [PKT_W-1:0] rxq_head, txq_head;
    logic             rxq_pop, rxq_push, txq_push, txq_flush;

    logic             t_rd_used, t_first_ok, t_second_ok, rel_start;
    logic [CNT_W-1:0] t_rd_cnt;
    logic [PKT_W-1:0] t_rd_idx, t_first_idx, t_second_idx;

    logic unused_cmd_bits;
    assign unused_cmd_bits = ^{cmd_word_i[15:8], cmd_word_i[4:SIZE_W], txq_full};

    assign op  = pma_op_e'(cmd_word_i[OP_LSB+2:OP_LSB]);
    assign acc = cmd_valid_i && (st_q.left == '0);

    assign c_alloc    = acc && (op == OP_ALLOC);
    assign c_reset    = acc && (op == OP_RESET);
    assign c_rx_drop  = acc && (op == OP_RX_DROP);
    assign c_rx_free  = acc && (op == OP_RX_FREE);
    assign c_free_pnr = acc && (op == OP_FREE_PNR);
    assign c_tx_push  = acc && (op == OP_TX_PUSH);
    assign c_tx_clear = acc && (op == OP_TX_CLEAR);

    // Demand of each requester in pages.
    assign need_rx   = CNT_W'(rx_pages_i) + 1'b1;
    assign need_host = CNT_W'(cmd_word_i[SIZE_W-1:0]) + 1'b1;

    // Receive side goes first, without the transmit reservation.
    assign rx_ok = rx_alloc_i && !c_reset && t_first_ok && !rxq_full
                   && (8'(need_rx) <= st_q.free);
    assign rx_take    = rx_ok ? 8'(need_rx) : 8'd0;
    assign left_pages = st_q.free - rx_take;

    assign host_pkt_ok   = rx_ok ? t_second_ok : t_first_ok;
    assign host_idx      = rx_ok ? t_second_idx : t_first_idx;
    assign host_need_sum = 9'(tx_reserve_i) + 9'(need_host);
    assign host_ok       = c_alloc && host_pkt_ok && (host_need_sum <= {1'b0, left_pages});
    assign host_take     = host_ok ? 8'(need_host) : 8'd0;

    // Release: pick the packet, free it in the table, count its pages back.
    assign t_rd_idx  = c_rx_free ? rxq_head : pnr_i;
    assign rel_start = (c_rx_free && !rxq_empty) || (c_free_pnr && t_rd_used);
    assign tick      = (st_q.left != '0);

    assign rxq_pop   = (c_rx_drop || c_rx_free) && !rxq_empty;
    assign rxq_push  = rx_ok;
    assign txq_push  = c_tx_push;
    assign txq_flush = c_reset || c_tx_clear;

    always_comb begin
        st_d = st_q;
        if (c_reset) begin
            st_d.free = 8'(NUM_PAGES);
            st_d.left = '0;
        end else begin
            st_d.free = st_q.free - rx_take - host_take + (tick ? 8'd1 : 8'd0);
            if (rel_start)  st_d.left = t_rd_cnt;
            else if (tick)  st_d.left = st_q.left - 1'b1;
            if (c_alloc)    st_d.result = host_ok ? {1'b0, host_idx} : RESULT_FAIL;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.free   <= 8'(NUM_PAGES);
            st_q.left   <= '0;
            st_q.result <= RESULT_FAIL;
        end else begin
            st_q <= st_d;
        end
    end

    pma_pkt_table #(
        .NUM_PKTS(NUM_PKTS),
        .CNT_W   (CNT_W),
        .IDX_W   (PKT_W)
    ) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_all_i (c_reset),
        .set_a_i     (rx_ok),
        .set_a_idx_i (t_first_idx),
        .set_a_cnt_i (need_rx),
        .set_b_i     (host_ok),
        .set_b_idx_i (host_idx),
        .set_b_cnt_i (need_host),
        .drop_i      (rel_start),
        .drop_idx_i  (t_rd_idx),
        .rd_idx_i    (t_rd_idx),
        .rd_used_o   (t_rd_used),
        .rd_cnt_o    (t_rd_cnt),
        .first_ok_o  (t_first_ok),
        .first_idx_o (t_first_idx),
        .second_ok_o (t_second_ok),
        .second_idx_o(t_second_idx)
    );

    pma_pkt_queue #(.DEPTH(NUM_PKTS), .W(PKT_W)) u_rxq (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush_i(c_reset),
        .push_i (rxq_push),
        .data_i (t_first_idx),
        .pop_i  (rxq_pop),
        .head_o (rxq_head),
        .empty_o(rxq_empty),
        .full_o (rxq_full)
    );

    pma_pkt_queue #(.DEPTH(NUM_PKTS), .W(PKT_W)) u_txq (
        .clk    (clk),
        .rst_n  (rst_n),
        .flush_i(txq_flush),
        .push_i (txq_push),
        .data_i (pnr_i),
        .pop_i  (tx_pop_i),
        .head_o (txq_head),
        .empty_o(txq_empty),
        .full_o (txq_full)
    );

    assign busy_o         = tick;
    assign alloc_result_o = st_q.result;
    assign mem_info_o     = {st_q.free, 8'(NUM_PAGES)};
    assign queue_status_o = {rxq_empty, rxq_head, txq_empty, txq_head};
    assign rx_grant_o     = rx_ok;
    assign rx_pkt_o       = t_first_idx;

endmodule

// File: rtl/pma_page_alloc_chk.sv
module pma_page_alloc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid_i,
    input logic [15:0] cmd_word_i,
    input logic        rx_alloc_i,
    input logic        rx_grant_o,
    input logic        busy_o,
    input logic [7:0]  alloc_result_o,
    input logic [15:0] queue_status_o,
    input logic [15:0] mem_info_o
);

    // R2
    free_le_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_info_o[15:8] <= mem_info_o[7:0]);

    // R4
    alloc_fail_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_word_i[7:5] == 3'b001 && !busy_o && !rx_alloc_i)
        |=> (!alloc_result_o[7] || mem_info_o[15:8] == $past(mem_info_o[15:8])));

    // R5
    rx_grant_queue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_grant_o |=> !queue_status_o[15]);

    // R10
    release_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !rx_grant_o) |=> (mem_info_o[15:8] == 8'($past(mem_info_o[15:8]) + 8'd1)));

    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && cmd_valid_i) |=> $stable(alloc_result_o));

    // R12
    reset_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_word_i[7:5] == 3'b010 && !busy_o)
        |=> (queue_status_o[15] && queue_status_o[7] && mem_info_o[15:8] == mem_info_o[7:0]));

endmodule

bind pma_page_alloc pma_page_alloc_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cmd_valid_i   (cmd_valid_i),
    .cmd_word_i    (cmd_word_i),
    .rx_alloc_i    (rx_alloc_i),
    .rx_grant_o    (rx_grant_o),
    .busy_o        (busy_o),
    .alloc_result_o(alloc_result_o),
    .queue_status_o(queue_status_o),
    .mem_info_o    (mem_info_o)
);

// File: tb/test_pma_page_alloc.sv
`timescale 1ns/1ps
module test_pma_page_alloc;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid_i = 1'b0;
    logic [15:0] cmd_word_i = '0;
    logic [6:0]  pnr_i = '0;
    logic [4:0]  tx_reserve_i = '0;
    logic        busy_o;
    logic [7:0]  alloc_result_o;
    logic [15:0] queue_status_o;
    logic [15:0] mem_info_o;
    logic        rx_alloc_i = 1'b0;
    logic [2:0]  rx_pages_i = '0;
    logic        rx_grant_o;
    logic [6:0]  rx_pkt_o;
    logic        tx_pop_i = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pma_page_alloc i_pma_page_alloc (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_word_i(cmd_word_i),
        .pnr_i(pnr_i), .tx_reserve_i(tx_reserve_i), .busy_o(busy_o),
        .alloc_result_o(alloc_result_o), .queue_status_o(queue_status_o),
        .mem_info_o(mem_info_o), .rx_alloc_i(rx_alloc_i), .rx_pages_i(rx_pages_i),
        .rx_grant_o(rx_grant_o), .rx_pkt_o(rx_pkt_o), .tx_pop_i(tx_pop_i)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_cmd(input logic [2:0] op, input logic [4:0] low);
        cmd_valid_i = 1'b1;
        cmd_word_i  = {8'h00, op, low};
        @(negedge clk);
        cmd_valid_i = 1'b0;
        cmd_word_i  = '0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    function automatic int free_pg();
        return int'(mem_info_o[15:8]);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state, R2 word layout
        check("R1 free", free_pg(), 16);
        check("R2 total", int'(mem_info_o[7:0]), 16);
        check("R1 queues", int'(queue_status_o), 'h8080);
        check("R1 result", int'(alloc_result_o), 'h80);
        check("R1 busy", int'(busy_o), 0);

        // R3 / R4 sweep over reservation and request size
        for (int rsv = 0; rsv <= 18; rsv += 3) begin
            for (int n = 1; n <= 8; n++) begin
                bit ok;
                do_cmd(3'b010, 5'd0);
                tx_reserve_i = 5'(rsv);
                do_cmd(3'b001, 5'(n - 1));
                ok = (16 >= rsv + n);
                check(ok ? "R3 sweep result" : "R4 sweep result",
                      int'(alloc_result_o), ok ? 0 : 'h80);
                check(ok ? "R3 sweep free" : "R4 sweep free", free_pg(), ok ? 16 - n : 16);
            end
        end
        tx_reserve_i = '0;

        // R3 lowest number first, fail when numbers run out
        do_cmd(3'b010, 5'd0);
        for (int i = 0; i < 8; i++) begin
            do_cmd(3'b001, 5'd0);
            check("R3 number order", int'(alloc_result_o), i);
        end
        do_cmd(3'b001, 5'd0);
        check("R3 out of numbers", int'(alloc_result_o), 'h80);
        check("R3 free after eight", free_pg(), 8);

        // R10 busy one cycle per page
        pnr_i = 7'd3;
        do_cmd(3'b101, 5'd0);
        cnt = 0;
        while (busy_o) begin cnt++; @(negedge clk); end
        check("R10 busy cycles 1", cnt, 1);
        check("R10 free after 1", free_pg(), 9);
        do_cmd(3'b001, 5'd1);
        check("R3 reuse number", int'(alloc_result_o), 3);
        check("R3 free after 2", free_pg(), 7);
        do_cmd(3'b101, 5'd0);
        cnt = 0;
        while (busy_o) begin cnt++; @(negedge clk); end
        check("R10 busy cycles 2", cnt, 2);
        check("R10 free after 2", free_pg(), 9);

        // R11 command during busy is ignored
        do_cmd(3'b001, 5'd2);
        check("R3 three pages", int'(alloc_result_o), 3);
        do_cmd(3'b101, 5'd0);
        check("R10 busy high", int'(busy_o), 1);
        do_cmd(3'b001, 5'd0);
        wait_idle();
        check("R11 result kept", int'(alloc_result_o), 3);
        check("R11 free", free_pg(), 9);

        // R14 freeing an unused number and no-op do nothing
        do_cmd(3'b101, 5'd0);
        check("R14 no busy", int'(busy_o), 0);
        check("R14 free", free_pg(), 9);
        do_cmd(3'b000, 5'd0);
        check("R14 nop free", free_pg(), 9);
        check("R14 nop result", int'(alloc_result_o), 3);

        // R5 receive ignores reservation
        do_cmd(3'b010, 5'd0);
        tx_reserve_i = 5'd20;
        do_cmd(3'b001, 5'd0);
        check("R4 reserve blocks host", int'(alloc_result_o), 'h80);
        rx_alloc_i = 1'b1; rx_pages_i = 3'd7;
        #1;
        check("R5 grant", int'(rx_grant_o), 1);
        check("R5 number", int'(rx_pkt_o), 0);
        @(negedge clk);
        rx_alloc_i = 1'b0;
        check("R5 free", free_pg(), 8);
        check("R5 rx queued", int'(queue_status_o[15:8]), 'h00);

        // R6 same-cycle receive and host allocation
        do_cmd(3'b010, 5'd0);
        tx_reserve_i = 5'd0;
        rx_alloc_i = 1'b1; rx_pages_i = 3'd2;
        cmd_valid_i = 1'b1; cmd_word_i = {8'h00, 3'b001, 5'd1};
        #1;
        check("R6 rx first grant", int'(rx_grant_o), 1);
        check("R6 rx first number", int'(rx_pkt_o), 0);
        @(negedge clk);
        check("R6 host gets next", int'(alloc_result_o), 1);
        check("R6 free both", free_pg(), 11);
        tx_reserve_i = 5'd4; rx_pages_i = 3'd7; cmd_word_i = {8'h00, 3'b001, 5'd4};
        #1;
        check("R6 rx number 2", int'(rx_pkt_o), 2);
        @(negedge clk);
        check("R6 host fails after rx", int'(alloc_result_o), 'h80);
        check("R6 free rx only", free_pg(), 3);
        tx_reserve_i = 5'd0; rx_pages_i = 3'd3; cmd_word_i = {8'h00, 3'b001, 5'd1};
        #1;
        check("R6 rx refused", int'(rx_grant_o), 0);
        @(negedge clk);
        rx_alloc_i = 1'b0; cmd_valid_i = 1'b0; cmd_word_i = '0;
        check("R6 host alone", int'(alloc_result_o), 3);
        check("R6 free host only", free_pg(), 1);
        check("R7 rx head", int'(queue_status_o[15:8]), 'h00);

        // R7 order, R9 remove keeps pages, R10 release frees
        do_cmd(3'b010, 5'd0);
        rx_pages_i = 3'd0;
        rx_alloc_i = 1'b1;
        repeat (3) @(negedge clk);
        rx_alloc_i = 1'b0;
        check("R7 head first", int'(queue_status_o[15:8]), 'h00);
        check("R7 free", free_pg(), 13);
        do_cmd(3'b011, 5'd0);
        check("R9 head next", int'(queue_status_o[15:8]), 'h01);
        check("R9 pages kept", free_pg(), 13);
        do_cmd(3'b100, 5'd0);
        wait_idle();
        check("R10 rx head after", int'(queue_status_o[15:8]), 'h02);
        check("R10 rx free", free_pg(), 14);
        do_cmd(3'b001, 5'd0);
        check("R9 number still held", int'(alloc_result_o), 1);

        // R8 transmit queue, R13 clear transmit
        pnr_i = 7'd1;
        do_cmd(3'b110, 5'd0);
        check("R8 tx head", int'(queue_status_o[7:0]), 'h01);
        pnr_i = 7'd2;
        do_cmd(3'b110, 5'd0);
        check("R8 tx head kept", int'(queue_status_o[7:0]), 'h01);
        tx_pop_i = 1'b1;
        @(negedge clk);
        tx_pop_i = 1'b0;
        check("R8 tx pop", int'(queue_status_o[7:0]), 'h02);
        do_cmd(3'b111, 5'd0);
        check("R13 tx empty", int'(queue_status_o[7:0]), 'h80);
        check("R13 rx kept", int'(queue_status_o[15:8]), 'h02);
        check("R13 free kept", free_pg(), 13);

        // R12 reset command
        do_cmd(3'b010, 5'd0);
        check("R12 queues", int'(queue_status_o), 'h8080);
        check("R12 free", free_pg(), 16);
        do_cmd(3'b001, 5'd0);
        check("R12 number zero", int'(alloc_result_o), 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule